// File: doc/BRIEF.md
# One's-Complement Accumulator Adder with Link Chain

This block performs the arithmetic for a 12-bit one's-complement machine. On each clock where `op_valid` is high, it takes the current accumulator, link bit and a memory operand word. It then performs one of three additions.

- Add-to-accumulator returns the end-around-carry sum.
- Add-to-memory returns the same sum and also presents it as a write-back word, raising a one-cycle write strobe.
- Link-add treats the words as unsigned. The link is a carry into the sum and back out of it, and the result goes to both the accumulator and memory.

The signed-overflow flag is held in a register. Only the two plain additions change it.

Alongside the arithmetic, a purely combinational test port evaluates a condition on the present accumulator or link. The conditions are zero (either signed zero), positive, and link clear. An invert bit negates the condition, so the surrounding sequencer can use the result as a skip decision. The sequencer supplies the operands and stores the results. Addressing and instruction decode are outside this block.

Top module: `ocu_unit`

## Requirements
- R1: With `op_sel`=0 (add-to-accumulator), `res_acc` one clock later equals the 12-bit one's-complement sum of `acc_in` and `opnd_in`. This sum is the 13-bit sum with its bit-12 carry added back into bit 0, keeping 12 bits. `res_link` takes `link_in`.
- R2: For `op_sel`=0 or 1, `ovf` one clock later is 1 exactly when `acc_in[11]` equals `opnd_in[11]` and the result's bit 11 differs from `opnd_in[11]`. Otherwise it is 0.
- R3: With `op_sel`=1 (add-to-memory), `res_acc` and `wb_data` both take the R1 sum one clock later. `res_link` takes `link_in`.
- R4: With `op_sel`=2 (link-add), the first step adds `link_in` to `acc_in`, and a carry out of bit 11 sets the link. The second step adds `opnd_in` to that result, and a carry out of that step also sets the link. The link is otherwise 0. The 12-bit result goes to `res_acc` and `wb_data`, and the link goes to `res_link`.
- R5: `ovf` keeps its value on any clock other than a valid `op_sel`=0 or 1.
- R6: `wb_en` is high for exactly the one cycle after a valid `op_sel`=1 or 2, and low otherwise. `wb_data` changes only when `wb_en` rises.
- R7: With `op_sel`=3 (reserved), `res_acc` takes `acc_in` and `res_link` takes `link_in`. No write occurs.
- R8: With `test_sel`=0 (zero test), the raw condition is true when `acc_in` is 12'o0000 or 12'o7777.
- R9: With `test_sel`=1, the raw condition is `acc_in[11]`==0. With `test_sel`=2, it is `link_in`==0. With `test_sel`=3, it is always false.
- R10: `skip` is the raw condition when `test_inv`=0 and its negation when `test_inv`=1, combinationally in the same cycle.
- R11: While `rst_n` is low, `res_acc`, `res_link`, `ovf`, `wb_data` and `wb_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Execute the selected operation this clock |
| op_sel | input | 2 | 0 add-acc, 1 add-mem, 2 link-add, 3 reserved |
| acc_in | input | 12 | Current accumulator |
| link_in | input | 1 | Current link bit |
| opnd_in | input | 12 | Memory operand word |
| test_sel | input | 2 | 0 zero, 1 positive, 2 link clear, 3 never |
| test_inv | input | 1 | Negate the selected test |
| res_acc | output | 12 | New accumulator |
| res_link | output | 1 | New link bit |
| ovf | output | 1 | Overflow flag |
| wb_data | output | 12 | Memory write-back word |
| wb_en | output | 1 | Write strobe, one cycle |
| skip | output | 1 | Test result |

## Verification
Some rules are checked by the assertions on every cycle:

- The write strobe follows only the memory-writing operations.
- The written word agrees with the new accumulator.
- The overflow flag is held on every other cycle, and mixed-sign additions clear it.
- The reserved operation passes its operands through.
- The zero and link tests match their definitions.

Only the bench's scenarios can show the exact sums. That covers end-around carry at the negative-zero boundary, the overflow cases in both sign directions, and the two-stage link carry. The same applies to the sequence in which the held overflow survives link-adds and idle cycles.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  typedef enum logic [1:0] {
    OP_ADD_ACC  = 2'd0,
    OP_ADD_MEM  = 2'd1,
    OP_LINK_ADD = 2'd2,
    OP_RSVD     = 2'd3
  } ocu_op_e;

  typedef enum logic [1:0] {
    TST_ZERO      = 2'd0,
    TST_POSITIVE  = 2'd1,
    TST_LINK_CLR  = 2'd2,
    TST_NEVER     = 2'd3
  } ocu_test_e;
endpackage

// File: rtl/ocu_endaround_add.sv
module ocu_endaround_add #(
  parameter int WIDTH = 12
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH-1:0] oc_add(input logic [WIDTH-1:0] x,
                                                input logic [WIDTH-1:0] y);
    logic [WIDTH:0] raw;
    logic [WIDTH:0] wrapped;
    raw     = {1'b0, x} + {1'b0, y};
    wrapped = {1'b0, raw[WIDTH-1:0]} + {{WIDTH{1'b0}}, raw[WIDTH]};
    return wrapped[WIDTH-1:0];
  endfunction

  function automatic logic sign_ovf(input logic xs, input logic ys, input logic rs);
    return (xs == ys) && (rs != ys);
  endfunction

  always_comb begin
    sum = oc_add(a, b);
    ovf = sign_ovf(a[MSB], b[MSB], sum[MSB]);
  end
endmodule

// File: rtl/ocu_link_add.sv
module ocu_link_add #(
  parameter int WIDTH = 12
) (
  input  logic [WIDTH-1:0] a,
  input  logic             link,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             link_out
);
  logic [WIDTH:0] stage1;
  logic [WIDTH:0] stage2;

  always_comb begin
    stage1   = {1'b0, a} + {{WIDTH{1'b0}}, link};
    stage2   = {1'b0, stage1[WIDTH-1:0]} + {1'b0, b};
    sum      = stage2[WIDTH-1:0];
    link_out = stage1[WIDTH] | stage2[WIDTH];
  end
endmodule

// File: rtl/ocu_acc_test.sv
module ocu_acc_test #(
  parameter int WIDTH = 12
) (
  input  logic [WIDTH-1:0] acc,
  input  logic             link,
  input  logic [1:0]       sel,
  input  logic             inv,
  output logic             raw,
  output logic             result
);
  import ocu_pkg::*;
  localparam int MSB = WIDTH - 1;

  logic all_ones;
  logic all_zero;

  always_comb begin
    all_ones = &acc;
    all_zero = ~|acc;
    unique case (ocu_test_e'(sel))
      TST_ZERO:     raw = all_ones | all_zero;
      TST_POSITIVE: raw = ~acc[MSB];
      TST_LINK_CLR: raw = ~link;
      default:      raw = 1'b0;
    endcase
    result = raw ^ inv;
  end
endmodule

// File: rtl/ocu_unit.sv
module ocu_unit #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [1:0]       op_sel,
  input  logic [WIDTH-1:0] acc_in,
  input  logic             link_in,
  input  logic [WIDTH-1:0] opnd_in,
  input  logic [1:0]       test_sel,
  input  logic             test_inv,
  output logic [WIDTH-1:0] res_acc,
  output logic             res_link,
  output logic             ovf,
  output logic [WIDTH-1:0] wb_data,
  output logic             wb_en,
  output logic             skip
);
  import ocu_pkg::*;

  logic [WIDTH-1:0] add_sum;
  logic             add_ovf;
  logic [WIDTH-1:0] lnk_sum;
  logic             lnk_carry;
  logic             test_raw;
  logic             signed_op;
  logic             mem_op;
  ocu_op_e          op;

  ocu_endaround_add #(.WIDTH(WIDTH)) u_add (
    .a(acc_in), .b(opnd_in), .sum(add_sum), .ovf(add_ovf)
  );

  ocu_link_add #(.WIDTH(WIDTH)) u_lnk (
    .a(acc_in), .link(link_in), .b(opnd_in), .sum(lnk_sum), .link_out(lnk_carry)
  );

  ocu_acc_test #(.WIDTH(WIDTH)) u_tst (
    .acc(acc_in), .link(link_in), .sel(test_sel), .inv(test_inv),
    .raw(test_raw), .result(skip)
  );

  always_comb begin
    op        = ocu_op_e'(op_sel);
    signed_op = op_valid && (op == OP_ADD_ACC || op == OP_ADD_MEM);
    mem_op    = op_valid && (op == OP_ADD_MEM || op == OP_LINK_ADD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_acc  <= '0;
      res_link <= 1'b0;
      ovf      <= 1'b0;
      wb_data  <= '0;
      wb_en    <= 1'b0;
    end else begin
      wb_en <= mem_op;
      if (signed_op) ovf <= add_ovf;
      if (op_valid) begin
        unique case (op)
          OP_ADD_ACC, OP_ADD_MEM: begin
            res_acc  <= add_sum;
            res_link <= link_in;
          end
          OP_LINK_ADD: begin
            res_acc  <= lnk_sum;
            res_link <= lnk_carry;
          end
          default: begin
            res_acc  <= acc_in;
            res_link <= link_in;
          end
        endcase
      end
      if (mem_op) wb_data <= (op == OP_LINK_ADD) ? lnk_sum : add_sum;
    end
  end
endmodule

// File: rtl/ocu_unit_chk.sv
module ocu_unit_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [1:0]       op_sel,
  input logic [WIDTH-1:0] acc_in,
  input logic             link_in,
  input logic [WIDTH-1:0] opnd_in,
  input logic [1:0]       test_sel,
  input logic             test_inv,
  input logic [WIDTH-1:0] res_acc,
  input logic             res_link,
  input logic             ovf,
  input logic [WIDTH-1:0] wb_data,
  input logic             wb_en,
  input logic             skip
);
  localparam int MSB = WIDTH - 1;

  AST_WB_ONLY_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == 2'd1 || op_sel == 2'd2)) |=> wb_en) // R6
    else $error("write strobe missing");
  AST_WB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && (op_sel == 2'd1 || op_sel == 2'd2)) |=> (!wb_en && $stable(wb_data))) // R6
    else $error("spurious write");
  AST_WB_EQ_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_data == res_acc)) // R3
    else $error("write word differs from accumulator");
  AST_OVF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_sel[1] == 1'b0) |=> $stable(ovf)) // R5
    else $error("overflow changed");
  AST_OVF_CLEAR_MIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel[1] == 1'b0 && acc_in[MSB] != opnd_in[MSB]) |=> !ovf) // R2
    else $error("overflow on mixed signs");
  AST_RSVD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 2'd3) |=> (res_acc == $past(acc_in) && res_link == $past(link_in))) // R7
    else $error("reserved op altered state");
  AST_ZERO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (test_sel == 2'd0 && (acc_in == '0 || acc_in == {WIDTH{1'b1}})) |-> (skip != test_inv)) // R8
    else $error("zero test");
  AST_LINK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (test_sel == 2'd2) |-> (skip == (link_in == test_inv))) // R9
    else $error("link test");
endmodule

bind ocu_unit ocu_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/ocu_unit_tb.sv
module ocu_unit_tb;
  localparam int W = 12;
  localparam int NV = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic [1:0]   op_sel = 2'd0;
  logic [W-1:0] acc_in = '0;
  logic         link_in = 1'b0;
  logic [W-1:0] opnd_in = '0;
  logic [1:0]   test_sel = 2'd0;
  logic         test_inv = 1'b0;
  logic [W-1:0] res_acc;
  logic         res_link;
  logic         ovf;
  logic [W-1:0] wb_data;
  logic         wb_en;
  logic         skip;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ocu_unit #(.WIDTH(W)) u_dut (.*);

  // op, acc, link, opnd | exp acc, exp link, exp ovf, exp wb_en
  localparam logic [41:0] VEC [NV] = '{
    {2'd0, 12'o0001, 1'b0, 12'o0002, 12'o0003, 1'b0, 1'b0, 1'b0},
    {2'd0, 12'o7777, 1'b0, 12'o0001, 12'o0001, 1'b0, 1'b0, 1'b0},
    {2'd0, 12'o3777, 1'b1, 12'o0001, 12'o4000, 1'b1, 1'b1, 1'b0},
    {2'd0, 12'o4000, 1'b0, 12'o4000, 12'o0001, 1'b0, 1'b1, 1'b0},
    {2'd0, 12'o7776, 1'b0, 12'o7776, 12'o7775, 1'b0, 1'b0, 1'b0},
    {2'd1, 12'o0100, 1'b0, 12'o0023, 12'o0123, 1'b0, 1'b0, 1'b1},
    {2'd1, 12'o2000, 1'b0, 12'o2000, 12'o4000, 1'b0, 1'b1, 1'b1},
    {2'd2, 12'o7777, 1'b1, 12'o0005, 12'o0005, 1'b1, 1'b1, 1'b1},
    {2'd2, 12'o0010, 1'b0, 12'o7770, 12'o0000, 1'b1, 1'b1, 1'b1},
    {2'd2, 12'o1234, 1'b1, 12'o0100, 12'o1335, 1'b0, 1'b1, 1'b1},
    {2'd3, 12'o5555, 1'b1, 12'o1111, 12'o5555, 1'b1, 1'b1, 1'b0},
    {2'd0, 12'o1111, 1'b0, 12'o2222, 12'o3333, 1'b0, 1'b0, 1'b0},
    {2'd2, 12'o0000, 1'b0, 12'o0000, 12'o0000, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %o expected %o", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] s, input logic [W-1:0] a, input logic l,
                        input logic [W-1:0] b);
    @(negedge clk);
    op_sel = s; acc_in = a; link_in = l; opnd_in = b; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic chk_test(input string req, input logic [1:0] s, input logic inv,
                          input logic [W-1:0] a, input logic l, input logic exp);
    @(negedge clk);
    test_sel = s; test_inv = inv; acc_in = a; link_in = l;
    #1;
    chk(req, {{(W-1){1'b0}}, skip}, {{(W-1){1'b0}}, exp});
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 acc", res_acc, '0);
    chk("R11 link", {11'd0, res_link}, '0);
    chk("R11 ovf", {11'd0, ovf}, '0);
    chk("R11 wb_data", wb_data, '0);
    chk("R11 wb_en", {11'd0, wb_en}, '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      run_op(v[41:40], v[39:28], v[27], v[26:15]);
      chk("R1/R3/R4/R7 acc", res_acc, v[14:3]);
      chk("R1/R4 link", {11'd0, res_link}, {11'd0, v[2]});
      chk("R2/R5 ovf", {11'd0, ovf}, {11'd0, v[1]});
      chk("R6 wb_en", {11'd0, wb_en}, {11'd0, v[0]});
      if (v[0]) chk("R3/R4 wb_data", wb_data, v[14:3]);
    end

    // R6: strobe drops after one cycle, wb_data kept across an add-to-accumulator
    run_op(2'd1, 12'o0007, 1'b0, 12'o0070);
    held = wb_data;
    chk("R3 wb_data", held, 12'o0077);
    @(negedge clk);
    chk("R6 strobe width", {11'd0, wb_en}, '0);
    run_op(2'd0, 12'o0001, 1'b0, 12'o0001);
    chk("R6 wb_data unchanged", wb_data, held);

    // R5: overflow survives idle, link-add and reserved op
    run_op(2'd0, 12'o3000, 1'b0, 12'o3000);
    chk("R2 ovf set", {11'd0, ovf}, 12'd1);
    repeat (2) @(negedge clk);
    chk("R5 ovf idle", {11'd0, ovf}, 12'd1);
    run_op(2'd2, 12'o0001, 1'b0, 12'o0001);
    chk("R5 ovf linkadd", {11'd0, ovf}, 12'd1);
    run_op(2'd3, 12'o0000, 1'b0, 12'o0000);
    chk("R5 ovf rsvd", {11'd0, ovf}, 12'd1);
    chk("R7 wb_en", {11'd0, wb_en}, '0);

    // R8..R10 tests
    chk_test("R8 zero +0", 2'd0, 1'b0, 12'o0000, 1'b0, 1'b1);
    chk_test("R8 zero -0", 2'd0, 1'b0, 12'o7777, 1'b0, 1'b1);
    chk_test("R8 zero 1", 2'd0, 1'b0, 12'o0001, 1'b0, 1'b0);
    chk_test("R8 zero 7776", 2'd0, 1'b0, 12'o7776, 1'b0, 1'b0);
    chk_test("R9 pos 3777", 2'd1, 1'b0, 12'o3777, 1'b0, 1'b1);
    chk_test("R9 pos 4000", 2'd1, 1'b0, 12'o4000, 1'b0, 1'b0);
    chk_test("R9 link 0", 2'd2, 1'b0, 12'o1234, 1'b0, 1'b1);
    chk_test("R9 link 1", 2'd2, 1'b0, 12'o1234, 1'b1, 1'b0);
    chk_test("R9 never", 2'd3, 1'b0, 12'o0000, 1'b0, 1'b0);
    chk_test("R10 inv zero", 2'd0, 1'b1, 12'o7777, 1'b0, 1'b0);
    chk_test("R10 inv pos", 2'd1, 1'b1, 12'o4000, 1'b0, 1'b1);
    chk_test("R10 inv never", 2'd3, 1'b1, 12'o0000, 1'b1, 1'b1);

    // R11 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 ovf async", {11'd0, ovf}, '0);
    chk("R11 acc async", res_acc, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule